// File: doc/BRIEF.md
# Beam Loss Threshold Alarm Processor

This block watches one channel of digitized beam-loss data and raises a latched alarm when the loss is too high. Twelve-bit samples arrive on a valid/ready stream, one per bunch slot, while the RF window input is high. Each accepted sample is tested in the same cycle against three limits. The first limit applies to the sample level. The second applies to the rise over the previous sample of the same window. The third applies to the running sum of the window's samples. Whichever limit trips first is recorded as the alarm cause.

Every new window starts from a clean state. The running sum, the previous-sample history and the capture write position are all reset when the window opens. The capture buffer stores the window's samples in arrival order. A registered read port returns the stored samples once the window has closed, so a loss transient can be examined after the event.

Back-pressure rules: the block raises `s_ready` only while the RF window is open, and it never stalls inside the window. Outside the window it refuses every sample, so those samples are neither checked nor stored. A sample is transferred on a clock edge where both `s_valid` and `s_ready` are high.

Top module: `loss_alarm_top`

## Requirements
- R1: `s_ready` follows `rf_gate`. A sample offered while `rf_gate` is low is not accepted, so it cannot set the alarm.
- R2: An accepted sample strictly greater than `thr_level` trips the alarm, with cause code 2'b01.
- R3: An accepted sample that exceeds the previously accepted sample of the same window by strictly more than `thr_step` trips the alarm, with cause code 2'b10. The first sample of a window is never step-checked, and history does not carry over from one window to the next.
- R4: The running sum of the window's accepted samples, including the current sample, trips the alarm with cause code 2'b11 when it is strictly greater than `thr_sum`. The sum clears when the window opens and is `SW` bits wide, so 3000 full-scale samples fit without overflow.
- R5: When several criteria trip on the same sample, the priority is level, then step, then sum. Once the alarm is set, `alarm_cause` keeps the first cause even if later samples trip other criteria.
- R6: Once the alarm is set, it stays set. Pulsing `alarm_clr` while `rf_gate` is low clears `alarm` and sets `alarm_cause` to 2'b00 on the next edge. Pulsing `alarm_clr` while `rf_gate` is high has no effect.
- R7: The alarm and its cause are visible right after the clock edge that accepts the tripping sample, which is one cycle of latency.
- R8: The k-th accepted sample of a window, counting from 0, is written at address k. Samples beyond `DEPTH`-1 are dropped. Addresses that the window did not write keep their older contents. `rd_data` shows the entry at `rd_addr` one clock after the address is presented.
- R9: After reset, `alarm` is 0 and `alarm_cause` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rf_gate | input | 1 | RF window; a rising edge opens a new window |
| s_valid | input | 1 | Sample valid |
| s_ready | output | 1 | Sample ready (high during the window) |
| s_data | input | DW | Loss sample |
| thr_level | input | DW | Single-sample limit |
| thr_step | input | DW | Sample-to-sample rise limit |
| thr_sum | input | SW | Window-sum limit |
| alarm_clr | input | 1 | Alarm clear, honoured outside the window |
| alarm | output | 1 | Latched alarm |
| alarm_cause | output | 2 | First cause: 00 none, 01 level, 10 step, 11 sum |
| rd_addr | input | $clog2(DEPTH) | Capture read address |
| rd_data | output | DW | Capture read data, one cycle after the address |

## Verification
All three criteria are due on the edge that accepts the sample. The bench therefore drives the sample half a cycle before that edge and reads `alarm`/`alarm_cause` half a cycle after it. It also confirms that the alarm is still low before that edge. A clear takes effect after one edge, and read data arrives one edge after the address. Each check samples at the falling edge that follows exactly that many rising edges. The sweeps run through every level value, a 16×16 grid of consecutive sample pairs, and the full-scale 3000-sample window.

// File: rtl/loss_pkg.sv
package loss_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'b00,
    CAUSE_LEVEL = 2'b01,
    CAUSE_STEP  = 2'b10,
    CAUSE_SUM   = 2'b11
  } cause_e;
endpackage

// File: rtl/loss_criteria.sv
// Three parallel checks on each accepted sample; hits are combinational.
module loss_criteria #(
  parameter int DW = 12,
  parameter int SW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gate_start,
  input  logic          acc,
  input  logic [DW-1:0] sample,
  input  logic [DW-1:0] thr_level,
  input  logic [DW-1:0] thr_step,
  input  logic [SW-1:0] thr_sum,
  output logic          hit_level,
  output logic          hit_step,
  output logic          hit_sum
);
  logic [DW-1:0] prev_q;
  logic          have_prev_q;
  logic [SW-1:0] sum_q;
  logic [SW-1:0] sum_base;
  logic [SW-1:0] sum_next;
  logic          prev_ok;

  always_comb begin
    sum_base  = gate_start ? '0 : sum_q;
    sum_next  = sum_base + SW'(sample);
    prev_ok   = have_prev_q && !gate_start;
    hit_level = acc && (sample > thr_level);
    hit_step  = acc && prev_ok && (sample > prev_q) && ((sample - prev_q) > thr_step);
    hit_sum   = acc && (sum_next > thr_sum);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q      <= '0;
      have_prev_q <= 1'b0;
      sum_q       <= '0;
    end else if (acc) begin
      prev_q      <= sample;
      have_prev_q <= 1'b1;
      sum_q       <= sum_next;
    end else if (gate_start) begin
      have_prev_q <= 1'b0;
      sum_q       <= '0;
    end
  end

  // R4: inside a window the sum never decreases
  a_r4_sum_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !gate_start) |=> (sum_q >= $past(sum_q)));
endmodule

// File: rtl/loss_latch.sv
// Latches the alarm and the first cause by priority.
module loss_latch
  import loss_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   gate,
  input  logic   clr,
  input  logic   hit_level,
  input  logic   hit_step,
  input  logic   hit_sum,
  output logic   alarm,
  output cause_e cause
);
  cause_e new_cause;
  logic   trip;

  always_comb begin
    trip = hit_level || hit_step || hit_sum;
    if (hit_level)     new_cause = CAUSE_LEVEL;
    else if (hit_step) new_cause = CAUSE_STEP;
    else if (hit_sum)  new_cause = CAUSE_SUM;
    else               new_cause = CAUSE_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alarm <= 1'b0;
      cause <= CAUSE_NONE;
    end else if (!alarm && trip) begin
      alarm <= 1'b1;
      cause <= new_cause;
    end else if (clr && !gate) begin
      alarm <= 1'b0;
      cause <= CAUSE_NONE;
    end
  end

  // R6: alarm stays set unless cleared outside the window
  a_r6_alarm_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm && !(clr && !gate)) |=> alarm);
  // R5: first cause is held while the alarm stays set
  a_r5_first_cause_held: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm && !(clr && !gate)) |=> $stable(cause));
  // R9: the cause is non-zero exactly when the alarm is set
  a_r9_cause_matches_alarm: assert property (@(posedge clk) disable iff (!rst_n)
    alarm == (cause != CAUSE_NONE));
endmodule

// File: rtl/loss_capture.sv
// Per-window transient buffer with a registered read port.
module loss_capture #(
  parameter int DW    = 12,
  parameter int DEPTH = 3072,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gate_start,
  input  logic          acc,
  input  logic [DW-1:0] sample,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam logic [PW-1:0] FULL = PW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr;
  logic [PW-1:0] pos;

  assign pos = gate_start ? '0 : wr_ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
    end else if (acc) begin
      wr_ptr <= (pos == FULL) ? FULL : pos + PW'(1);
    end else if (gate_start) begin
      wr_ptr <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (acc && (pos < FULL)) mem[pos[AW-1:0]] <= sample;
    rd_data <= (PW'(rd_addr) < FULL) ? mem[rd_addr] : '0;
  end

  // R8: write position never passes the buffer end
  a_r8_ptr_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ptr <= FULL);
endmodule

// File: rtl/loss_alarm_top.sv
module loss_alarm_top
  import loss_pkg::*;
#(
  parameter int DW    = 12,
  parameter int SW    = 24,
  parameter int DEPTH = 3072,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rf_gate,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [DW-1:0] s_data,
  input  logic [DW-1:0] thr_level,
  input  logic [DW-1:0] thr_step,
  input  logic [SW-1:0] thr_sum,
  input  logic          alarm_clr,
  output logic          alarm,
  output logic [1:0]    alarm_cause,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic   gate_q;
  logic   gate_start;
  logic   acc;
  logic   hit_level, hit_step, hit_sum;
  cause_e cause;

  always_ff @(posedge clk) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= rf_gate;
  end

  assign gate_start  = rf_gate && !gate_q;
  assign s_ready     = rf_gate;
  assign acc         = s_valid && s_ready;
  assign alarm_cause = cause;

  loss_criteria #(.DW(DW), .SW(SW)) u_crit (
    .clk(clk), .rst_n(rst_n), .gate_start(gate_start), .acc(acc), .sample(s_data),
    .thr_level(thr_level), .thr_step(thr_step), .thr_sum(thr_sum),
    .hit_level(hit_level), .hit_step(hit_step), .hit_sum(hit_sum)
  );

  loss_latch u_latch (
    .clk(clk), .rst_n(rst_n), .gate(rf_gate), .clr(alarm_clr),
    .hit_level(hit_level), .hit_step(hit_step), .hit_sum(hit_sum),
    .alarm(alarm), .cause(cause)
  );

  loss_capture #(.DW(DW), .DEPTH(DEPTH)) u_cap (
    .clk(clk), .rst_n(rst_n), .gate_start(gate_start), .acc(acc), .sample(s_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // R2, R7: a level trip shows on the very next edge
  a_r2_level_next_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && rf_gate && (s_data > thr_level) && !alarm) |=> (alarm && alarm_cause == 2'b01));
  // R1: nothing outside the window can raise the alarm
  a_r1_no_trip_outside: assert property (@(posedge clk) disable iff (!rst_n)
    (!rf_gate && !alarm) |=> !alarm);
endmodule

// File: tb/sim_loss_alarm_top.sv
`timescale 1ns/1ps
module sim_loss_alarm_top;
  localparam int DW = 12, SW = 24, DEPTH = 8, AW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rf_gate = 1'b0, s_valid = 1'b0, alarm_clr = 1'b0;
  logic s_ready, alarm;
  logic [DW-1:0] s_data = '0, thr_level = '0, thr_step = '0, rd_data;
  logic [SW-1:0] thr_sum = '0;
  logic [1:0] alarm_cause;
  logic [AW-1:0] rd_addr = '0;
  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  loss_alarm_top #(.DW(DW), .SW(SW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .rf_gate(rf_gate), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .thr_level(thr_level), .thr_step(thr_step), .thr_sum(thr_sum),
    .alarm_clr(alarm_clr), .alarm(alarm), .alarm_cause(alarm_cause),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic open_gate();
    rf_gate = 1'b1; @(negedge clk);
  endtask
  task automatic close_gate();
    rf_gate = 1'b0; @(negedge clk);
  endtask
  task automatic send(int v);
    s_valid = 1'b1; s_data = DW'(v); @(negedge clk); s_valid = 1'b0;
  endtask
  task automatic clear();
    alarm_clr = 1'b1; @(negedge clk); alarm_clr = 1'b0;
  endtask
  task automatic limits(int lv, int st, int sm);
    thr_level = DW'(lv); thr_step = DW'(st); thr_sum = SW'(sm);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 alarm", alarm, 0);
    chk("R9 cause", alarm_cause, 0);
    chk("R1 ready low", s_ready, 0);

    // R1: samples outside the window are refused
    limits(0, 0, 0);
    s_valid = 1'b1; s_data = 12'd4095;
    repeat (2) @(negedge clk);
    s_valid = 1'b0;
    chk("R1 no trip outside", alarm, 0);

    // R2: sweep every level against a fixed limit
    limits(2000, 4095, 'hFFFFFF);
    for (int v = 0; v < 4096; v++) begin
      open_gate();
      send(v);
      chk("R2 level", alarm, (v > 2000) ? 1 : 0);
      if (v > 2000) chk("R2 cause", alarm_cause, 1);
      close_gate();
      clear();
    end

    // R7: alarm low before the accepting edge, high right after it
    open_gate();
    chk("R1 ready high", s_ready, 1);
    s_valid = 1'b1; s_data = 12'd4000;
    chk("R7 before edge", alarm, 0);
    @(negedge clk); s_valid = 1'b0;
    chk("R7 after edge", alarm, 1);
    // R6: clear while the window is open is ignored
    clear();
    chk("R6 clear in gate alarm", alarm, 1);
    chk("R6 clear in gate cause", alarm_cause, 1);
    close_gate();
    clear();
    chk("R6 cleared alarm", alarm, 0);
    chk("R6 cleared cause", alarm_cause, 0);

    // R3: grid of consecutive pairs
    limits(4095, 500, 'hFFFFFF);
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        int va = a * 273, vb = b * 273;
        bit e = (vb > va) && (vb - va > 500);
        open_gate();
        send(va); send(vb);
        chk("R3 step", alarm, e ? 1 : 0);
        if (e) chk("R3 cause", alarm_cause, 2);
        close_gate();
        clear();
      end
    end
    // R3: first sample of a window has no history, even across windows
    limits(4095, 0, 'hFFFFFF);
    open_gate(); send(4000);
    chk("R3 first sample", alarm, 0);
    close_gate();
    open_gate(); send(0); close_gate();
    open_gate(); send(4000);
    chk("R3 no carry", alarm, 0);
    close_gate(); clear();

    // R4: sum limit equality and crossing
    limits(4095, 4095, 900);
    open_gate();
    for (int i = 0; i < 3; i++) send(300);
    chk("R4 sum equal", alarm, 0);
    send(300);
    chk("R4 sum over", alarm, 1);
    chk("R4 cause", alarm_cause, 3);
    close_gate(); clear();
    // R4: sum clears when a new window opens
    open_gate();
    for (int i = 0; i < 3; i++) send(300);
    close_gate();
    open_gate(); send(300);
    chk("R4 restart", alarm, 0);
    close_gate(); clear();
    // R4: 3000 full-scale samples, no overflow
    limits(4095, 4095, 4095 * 3000 - 1);
    open_gate();
    for (int i = 0; i < 2999; i++) send(4095);
    chk("R4 full scale before", alarm, 0);
    send(4095);
    chk("R4 full scale after", alarm, 1);
    chk("R4 full scale cause", alarm_cause, 3);
    close_gate(); clear();

    // R5: priority and first-cause hold
    limits(100, 4095, 50);
    open_gate(); send(200);
    chk("R5 level over sum", alarm_cause, 1);
    close_gate(); clear();
    limits(4095, 100, 250);
    open_gate(); send(10); send(300);
    chk("R5 step over sum", alarm_cause, 2);
    close_gate(); clear();
    limits(3000, 4095, 500);
    open_gate(); send(400);
    chk("R5 no trip yet", alarm, 0);
    send(400);
    chk("R5 sum first", alarm_cause, 3);
    send(4000);
    chk("R5 cause held", alarm_cause, 3);
    chk("R5 alarm held", alarm, 1);
    close_gate(); clear();

    // R8: capture with overflow, then partial overwrite
    limits(4095, 4095, 'hFFFFFF);
    open_gate();
    for (int i = 0; i < DEPTH + 2; i++) send(10 + i);
    close_gate();
    for (int i = 0; i < DEPTH; i++) begin
      rd_addr = AW'(i); @(negedge clk);
      chk("R8 capture", rd_data, 10 + i);
    end
    open_gate();
    for (int i = 0; i < 3; i++) send(50 + i);
    close_gate();
    for (int i = 0; i < DEPTH; i++) begin
      rd_addr = AW'(i); @(negedge clk);
      chk("R8 rewrite", rd_data, (i < 3) ? 50 + i : 10 + i);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule